// File: doc/BRIEF.md
# Execute Stage with ALU Decode

This block is the execute step of a five-stage in-order pipeline. Each cycle it takes the decoded operands and control groups handed over from the decode step, works out which ALU operation the instruction needs from a two-bit operation class and the six-bit function field, runs the ALU, picks the destination register number, adds the immediate to the next-PC value to form a branch target, and captures all of it in the register that feeds the memory step.

The function field is taken from the low six bits of the extended immediate, since both come from the same instruction bits. The branch target is the next-PC plus the raw extended offset; no scaling by four is applied. The branch decision itself (branch strobe AND zero flag) is made by the memory step from the latched outputs. Combinations that map to no supported operation produce a defined "bad" select code, a zero result and a raised invalid flag, so the block stays deterministic.

Top module: `exec_stage`

## Requirements
- R1: While rstN is low, every registered output (wbCtlOut, memCtlOut, branchTarget, zeroOut, aluResult, storeData, destReg, invalidOut) reads zero.
- R2: exCtlIn[2:1] is the operation class. Class 00 gives select 3'b010 (add) and class 01 gives 3'b110 (subtract), whatever the function field holds.
- R3: With class 10 the function field immExt[5:0] decodes as 6'b100000 to 3'b010, 6'b100010 to 3'b110, 6'b100100 to 3'b000 (and), 6'b100101 to 3'b001 (or), 6'b101010 to 3'b111 (set-less-than); the select appears combinationally on aluSel.
- R4: Class 11, or class 10 with any other function value, gives select 3'b011; one clock later invalidOut is 1, aluResult is zero and zeroOut is 1.
- R5: Select 010, 110, 000, 001 produce A+B, A-B, A&B and A|B modulo 2^32 in aluResult one clock after the inputs.
- R6: Select 111 compares A and B as signed two's-complement numbers and yields 1 when A<B, else 0, with bits 31:1 clear.
- R7: zeroOut is 1 exactly when the latched aluResult is zero.
- R8: exCtlIn[0] picks ALU operand B: 0 selects opB, 1 selects immExt.
- R9: exCtlIn[3] picks the destination: 1 latches rdField, 0 latches rtField, into destReg.
- R10: branchTarget is nextPcIn + immExt modulo 2^32, without a shift, one clock later.
- R11: wbCtlIn, memCtlIn and opB appear unchanged on wbCtlOut, memCtlOut and storeData one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wbCtlIn | input | 2 | Write-back control group |
| memCtlIn | input | 3 | Memory control group |
| exCtlIn | input | 4 | [3] destination pick, [2:1] operation class, [0] operand-B pick |
| nextPcIn | input | 32 | Next-PC value |
| opA | input | 32 | First register operand |
| opB | input | 32 | Second register operand |
| immExt | input | 32 | Sign-extended immediate; bits 5:0 carry the function field |
| rtField | input | 5 | Instruction bits 20:16 |
| rdField | input | 5 | Instruction bits 15:11 |
| aluSel | output | 3 | Combinational ALU select from the decoder |
| wbCtlOut | output | 2 | Latched write-back group |
| memCtlOut | output | 3 | Latched memory group |
| branchTarget | output | 32 | Latched branch target |
| zeroOut | output | 1 | Latched zero flag |
| aluResult | output | 32 | Latched ALU result |
| storeData | output | 32 | Latched second register operand |
| destReg | output | 5 | Latched destination register number |
| invalidOut | output | 1 | Latched invalid-operation flag |

## Verification
The assertions assume the inputs are driven to known values from time zero and change only between clock edges, so that the previous-cycle inputs they compare against are always defined once reset is released. The bench drives every input on the falling edge from the start, holds reset low with non-zero data to expose any leak, and then walks through each decode pair, both operand-B picks, both destination picks, signed comparisons across the sign boundary and negative branch offsets, checking each registered output against a behavioural model on the following falling edge.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int FUNCT_W = 6;
  localparam int CLASS_W = 2;
  localparam int WB_W    = 2;
  localparam int MEM_W   = 3;
  localparam int EXC_W   = 4;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_BAD = 3'b011,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_code_e;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

  typedef struct packed {
    alu_code_e code;
    logic      invalid;
    logic      useImm;
    logic      useRd;
  } ex_strobe_t;
endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
(
  input  logic [EXC_W-1:0]   exCtl,
  input  logic [FUNCT_W-1:0] funct,
  output ex_strobe_t         strobe
);
  logic [CLASS_W-1:0] opClass;
  assign opClass = exCtl[2:1];

  always_comb begin
    strobe.useImm  = exCtl[0];
    strobe.useRd   = exCtl[3];
    strobe.invalid = 1'b0;
    strobe.code    = ALU_BAD;
    unique case (opClass)
      2'b00: strobe.code = ALU_ADD;
      2'b01: strobe.code = ALU_SUB;
      2'b10: begin
        case (funct)
          FN_ADD:  strobe.code = ALU_ADD;
          FN_SUB:  strobe.code = ALU_SUB;
          FN_AND:  strobe.code = ALU_AND;
          FN_OR:   strobe.code = ALU_OR;
          FN_SLT:  strobe.code = ALU_SLT;
          default: begin
            strobe.code    = ALU_BAD;
            strobe.invalid = 1'b1;
          end
        endcase
      end
      default: begin
        strobe.code    = ALU_BAD;
        strobe.invalid = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ex_strobe_t        strobe,
  input  logic [WB_W-1:0]   wbCtlIn,
  input  logic [MEM_W-1:0]  memCtlIn,
  input  logic [DATA_W-1:0] nextPcIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] immExt,
  input  logic [REG_W-1:0]  rtField,
  input  logic [REG_W-1:0]  rdField,
  output logic [WB_W-1:0]   wbCtlOut,
  output logic [MEM_W-1:0]  memCtlOut,
  output logic [DATA_W-1:0] branchTarget,
  output logic              zeroOut,
  output logic [DATA_W-1:0] aluResult,
  output logic [DATA_W-1:0] storeData,
  output logic [REG_W-1:0]  destReg,
  output logic              invalidOut
);
  logic [DATA_W-1:0] operandB;
  logic [DATA_W-1:0] aluNext;
  logic [DATA_W-1:0] targetNext;
  logic [REG_W-1:0]  destNext;

  assign operandB   = strobe.useImm ? immExt : opB;
  assign targetNext = nextPcIn + immExt;
  assign destNext   = strobe.useRd ? rdField : rtField;

  always_comb begin
    case (strobe.code)
      ALU_ADD: aluNext = opA + operandB;
      ALU_SUB: aluNext = opA - operandB;
      ALU_AND: aluNext = opA & operandB;
      ALU_OR:  aluNext = opA | operandB;
      ALU_SLT: aluNext = {{(DATA_W-1){1'b0}}, ($signed(opA) < $signed(operandB))};
      default: aluNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbCtlOut     <= '0;
      memCtlOut    <= '0;
      branchTarget <= '0;
      zeroOut      <= 1'b0;
      aluResult    <= '0;
      storeData    <= '0;
      destReg      <= '0;
      invalidOut   <= 1'b0;
    end else begin
      wbCtlOut     <= wbCtlIn;
      memCtlOut    <= memCtlIn;
      branchTarget <= targetNext;
      zeroOut      <= (aluNext == '0);
      aluResult    <= aluNext;
      storeData    <= opB;
      destReg      <= destNext;
      invalidOut   <= strobe.invalid;
    end
  end

  // checker state: primed marks one edge since reset, wasSlt remembers a comparison
  logic primed;
  logic wasSlt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed <= 1'b0;
      wasSlt <= 1'b0;
    end else begin
      primed <= 1'b1;
      wasSlt <= (strobe.code == ALU_SLT);
    end
  end

  assert_invalid_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    invalidOut |-> (aluResult == '0 && zeroOut));

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (zeroOut == (aluResult == '0)));

  assert_slt_single_bit_R6: assert property (@(posedge clk) disable iff (!rstN)
    wasSlt |-> (aluResult[DATA_W-1:1] == '0));

  assert_branch_sum_R10: assert property (@(posedge clk) disable iff (!rstN)
    primed |=> (branchTarget == $past(nextPcIn) + $past(immExt)));

  assert_dest_pick_R9: assert property (@(posedge clk) disable iff (!rstN)
    primed |=> (destReg == ($past(strobe.useRd) ? $past(rdField) : $past(rtField))));

  assert_store_pass_R11: assert property (@(posedge clk) disable iff (!rstN)
    primed |=> (storeData == $past(opB)));
endmodule

// File: rtl/exec_stage.sv
module exec_stage
  import exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        wbCtlIn,
  input  logic [2:0]        memCtlIn,
  input  logic [3:0]        exCtlIn,
  input  logic [DATA_W-1:0] nextPcIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] immExt,
  input  logic [REG_W-1:0]  rtField,
  input  logic [REG_W-1:0]  rdField,
  output logic [2:0]        aluSel,
  output logic [1:0]        wbCtlOut,
  output logic [2:0]        memCtlOut,
  output logic [DATA_W-1:0] branchTarget,
  output logic              zeroOut,
  output logic [DATA_W-1:0] aluResult,
  output logic [DATA_W-1:0] storeData,
  output logic [REG_W-1:0]  destReg,
  output logic              invalidOut
);
  ex_strobe_t strobe;

  exec_ctrl u_ctrl (
    .exCtl  (exCtlIn),
    .funct  (immExt[FUNCT_W-1:0]),
    .strobe (strobe)
  );

  assign aluSel = strobe.code;

  exec_datapath #(.DATA_W(DATA_W), .REG_W(REG_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wbCtlIn      (wbCtlIn),
    .memCtlIn     (memCtlIn),
    .nextPcIn     (nextPcIn),
    .opA          (opA),
    .opB          (opB),
    .immExt       (immExt),
    .rtField      (rtField),
    .rdField      (rdField),
    .wbCtlOut     (wbCtlOut),
    .memCtlOut    (memCtlOut),
    .branchTarget (branchTarget),
    .zeroOut      (zeroOut),
    .aluResult    (aluResult),
    .storeData    (storeData),
    .destReg      (destReg),
    .invalidOut   (invalidOut)
  );
endmodule

// File: tb/exec_stage_test.sv
`timescale 1ns/1ps
module exec_stage_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  wbCtlIn = '0;
  logic [2:0]  memCtlIn = '0;
  logic [3:0]  exCtlIn = '0;
  logic [31:0] nextPcIn = '0, opA = '0, opB = '0, immExt = '0;
  logic [4:0]  rtField = '0, rdField = '0;
  logic [2:0]  aluSel;
  logic [1:0]  wbCtlOut;
  logic [2:0]  memCtlOut;
  logic [31:0] branchTarget, aluResult, storeData;
  logic        zeroOut, invalidOut;
  logic [4:0]  destReg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  exec_stage uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] refSel(input logic [1:0] cls, input logic [5:0] fn);
    if (cls == 2'b00) return 3'b010;
    if (cls == 2'b01) return 3'b110;
    if (cls == 2'b10) begin
      if (fn == 6'b100000) return 3'b010;
      if (fn == 6'b100010) return 3'b110;
      if (fn == 6'b100100) return 3'b000;
      if (fn == 6'b100101) return 3'b001;
      if (fn == 6'b101010) return 3'b111;
    end
    return 3'b011;
  endfunction

  function automatic logic [31:0] refAlu(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
    int sa, sb;
    sa = a; sb = b;
    case (s)
      3'b010: return a + b;
      3'b110: return a - b;
      3'b000: return a & b;
      3'b001: return a | b;
      3'b111: return (sa < sb) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  // one instruction: drive at falling edge, check decode, then registered outputs next falling edge
  task automatic step(input string tag, input logic [3:0] ex, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] imm, input logic [31:0] npc,
                      input logic [4:0] rt, input logic [4:0] rd,
                      input logic [1:0] wb, input logic [2:0] m);
    logic [2:0]  eSel;
    logic [31:0] bOp, eRes;
    exCtlIn = ex; opA = a; opB = b; immExt = imm; nextPcIn = npc;
    rtField = rt; rdField = rd; wbCtlIn = wb; memCtlIn = m;
    eSel = refSel(ex[2:1], imm[5:0]);
    bOp  = ex[0] ? imm : b;
    eRes = refAlu(eSel, a, bOp);
    #1;
    check({tag, " select R2/R3/R4"}, {29'd0, aluSel}, {29'd0, eSel});
    @(posedge clk);
    @(negedge clk);
    check({tag, " result R5 R6 R8"}, aluResult, eRes);
    check({tag, " zero R7"}, {31'd0, zeroOut}, {31'd0, (eRes == 0)});
    check({tag, " invalid R4"}, {31'd0, invalidOut}, {31'd0, (eSel == 3'b011)});
    check({tag, " branch R10"}, branchTarget, npc + imm);
    check({tag, " dest R9"}, {27'd0, destReg}, {27'd0, (ex[3] ? rd : rt)});
    check({tag, " store R11"}, storeData, b);
    check({tag, " ctl R11"}, {27'd0, wbCtlOut, memCtlOut}, {27'd0, wb, m});
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset with busy inputs
    @(negedge clk);
    exCtlIn = 4'b1100; opA = 32'h1234; opB = 32'h55; immExt = 32'h20; nextPcIn = 32'h40;
    rtField = 5'd3; rdField = 5'd9; wbCtlIn = 2'b11; memCtlIn = 3'b111;
    repeat (3) @(negedge clk);
    check("reset R1", {aluResult[15:0], 7'd0, wbCtlOut, memCtlOut, zeroOut, invalidOut, 2'd0}, 32'd0);
    check("reset R1 target", branchTarget | storeData, 32'd0);
    check("reset R1 dest", {27'd0, destReg}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // class 00 / 01 ignore function field (R2), immediate operand (R8)
    step("ld",   4'b0001, 32'd100, 32'd7, 32'h0000_002A, 32'd8, 5'd2, 5'd17, 2'b11, 3'b010);
    step("st",   4'b0001, 32'd100, 32'd7, 32'hFFFF_FFFC, 32'd12, 5'd4, 5'd1, 2'b00, 3'b001);
    step("beq",  4'b0010, 32'd55, 32'd55, 32'h0000_0020, 32'd16, 5'd5, 5'd6, 2'b00, 3'b100);
    step("bne",  4'b0010, 32'd55, 32'd54, 32'hFFFF_FFF0, 32'd20, 5'd5, 5'd6, 2'b00, 3'b100);
    // R-type (R3, R5, R9 rd)
    step("add",  4'b1100, 32'hFFFF_FFFF, 32'd2, 32'h0000_1020, 32'd24, 5'd1, 5'd3, 2'b10, 3'b000);
    step("sub",  4'b1100, 32'd5, 32'd9, 32'h0000_2022, 32'd28, 5'd1, 5'd4, 2'b10, 3'b000);
    step("and",  4'b1100, 32'hF0F0_AAAA, 32'h0FF0_FF00, 32'h0000_0024, 32'd32, 5'd2, 5'd5, 2'b10, 3'b000);
    step("or",   4'b1100, 32'hF000_0001, 32'h000F_0010, 32'h0000_0025, 32'd36, 5'd2, 5'd6, 2'b10, 3'b000);
    // signed set-less-than (R6)
    step("sltN", 4'b1100, 32'hFFFF_FFFB, 32'd3, 32'h0000_002A, 32'd40, 5'd7, 5'd8, 2'b10, 3'b000);
    step("sltP", 4'b1100, 32'd3, 32'hFFFF_FFFB, 32'h0000_002A, 32'd44, 5'd7, 5'd8, 2'b10, 3'b000);
    step("sltE", 4'b1100, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_002A, 32'd48, 5'd7, 5'd9, 2'b10, 3'b000);
    // invalid pairs (R4)
    step("badF", 4'b1100, 32'd8, 32'd8, 32'h0000_0007, 32'd52, 5'd10, 5'd11, 2'b10, 3'b000);
    step("cls3", 4'b1110, 32'd8, 32'd9, 32'h0000_0020, 32'd56, 5'd12, 5'd13, 2'b01, 3'b011);
    // class 10 with immediate operand and rt destination (R8, R9)
    step("immR", 4'b0101, 32'd1000, 32'd1, 32'h0000_00A0, 32'd60, 5'd14, 5'd15, 2'b01, 3'b000);
    step("wrap", 4'b0000, 32'hFFFF_FFFF, 32'd1, 32'hFFFF_FF00, 32'h0000_0010, 5'd31, 5'd0, 2'b11, 3'b111);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule